// File: doc/BRIEF.md
# Handshaked Serial Word Receiver

This block collects one data word from a serial link, one bit at a time, using a ready/strobe handshake with the sender. Software arms it with a one-cycle enable pulse. The receiver then raises its ready line and waits for the sender's bit strobe. Each strobed bit is shifted into a word register, and a bit counter tracks progress through the word. When the word is full, the block raises a wakeup. The wakeup stays high until a read pulse, and during that pulse the word register is presented on the output bus.

The sender can flag a bit as the final one of its message. If that flag arrives before the word is full, the receiver stops handshaking and fills the remaining positions with zeros by itself. A read pulse also serves as an abort: issued while a word is still arriving, it returns the receiver to idle.

Top module: `hs_deser`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ready_o` and `wake_o` are 0 and `word_o` is all zeros.
- R2: In idle, `strobe_i` and `read_i` have no effect: `ready_o` and `wake_o` stay 0. An `enable_i` pulse makes `ready_o` high on the following cycle.
- R3: `ready_o` is high only while the receiver waits for a bit. It falls on the cycle after a strobe is sampled with `ready_o` high.
- R4: Bits are stored first-received-most-significant: after a full word, the first bit received appears in `word_o[15]` and the last in `word_o[0]`.
- R5: After a bit is accepted, `ready_o` stays low for as long as `strobe_i` stays high. It rises again on the cycle after `strobe_i` is seen low, unless the word is complete.
- R6: After the sixteenth bit is strobed in, `wake_o` rises and `ready_o` stays low.
- R7: `wake_o` holds until a read pulse. During that pulse `word_o` carries the word. With no marker pending, the read returns the receiver to idle, so `wake_o` is 0 on the next cycle. Outside a read in wakeup, `word_o` is 0.
- R8: If `last_i` is high when bit n (1 ≤ n ≤ 16) is strobed in, the word holds those n bits in its top n positions and zeros below them. No further strobes are needed.
- R9: When a word ended with the `last_i` marker, the first read presents the word and leaves `wake_o` high. The second read presents the same word and clears `wake_o`.
- R10: A read pulse while a word is arriving (waiting for a bit, or mid-handshake) returns the receiver to idle: `ready_o` and `wake_o` go to 0 and stay there. A later enable starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | One-cycle pulse that arms reception of a word |
| strobe_i | input | 1 | Sender's bit-available strobe |
| data_i | input | 1 | Serial data bit, valid with the strobe |
| last_i | input | 1 | Marks the strobed bit as the final bit of the message |
| read_i | input | 1 | Read pulse; takes the word, or aborts reception |
| ready_o | output | 1 | Ready for the next bit |
| wake_o | output | 1 | Word available |
| word_o | output | 16 | Received word, driven during a read in wakeup, else 0 |

## Verification
The situation hardest to reach from the ports is an abort while the receiver is mid-handshake. In that state `ready_o` is already low, so the abort cannot be seen directly. The bench therefore keeps the strobe high after a bit, so the receiver stays in the handshake state. It issues the read there, then drops the strobe. An aborted receiver keeps `ready_o` low. A receiver that was not aborted would raise `ready_o` one cycle later, so the difference shows at the port. The padding path is swept over every cut-off length from 1 to 16 bits, with the expected word computed by masking the sent pattern.

// File: rtl/hs_deser_pkg.sv
package hs_deser_pkg;
   // State codes are fixed; unused codes fall back to idle.
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WAIT = 3'd1,
      ST_HAND = 3'd2,
      ST_WAKE = 3'd3,
      ST_CLK  = 3'd5
   } state_e;
endpackage

// File: rtl/hs_deser_fsm.sv
module hs_deser_fsm
   import hs_deser_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   enable_i,
   input  logic   strobe_i,
   input  logic   read_i,
   input  logic   cnt_full,
   input  logic   pad,
   output state_e state_q,
   output state_e state_d
);
   always_comb begin
      state_d = ST_IDLE;
      case (state_q)
         ST_IDLE: state_d = enable_i ? ST_WAIT : ST_IDLE;
         ST_WAIT: begin
            if (read_i)        state_d = ST_IDLE;
            else if (strobe_i) state_d = ST_CLK;
            else               state_d = ST_WAIT;
         end
         ST_CLK:  state_d = read_i ? ST_IDLE : ST_HAND;
         ST_HAND: begin
            if (read_i)        state_d = ST_IDLE;
            else if (cnt_full) state_d = ST_WAKE;
            else if (pad)      state_d = ST_CLK;
            else if (strobe_i) state_d = ST_HAND;
            else               state_d = ST_WAIT;
         end
         ST_WAKE: begin
            if (read_i && !pad) state_d = ST_IDLE;
            else                state_d = ST_WAKE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end
endmodule

// File: rtl/hs_deser_dp.sv
module hs_deser_dp
   import hs_deser_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter bit MSB_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  state_e            state_q,
   input  state_e            state_d,
   input  logic              data_i,
   input  logic              last_i,
   input  logic              read_i,
   output logic [WORD_W-1:0] word,
   output logic              cnt_full,
   output logic              pad_q
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

   logic              shift_en;
   logic              shift_bit;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] word_nx;

   always_comb begin
      shift_en  = (state_d == ST_CLK) &&
                  ((state_q == ST_WAIT) || (state_q == ST_HAND));
      shift_bit = (state_q == ST_WAIT) ? data_i : 1'b0;
   end

   generate
      if (MSB_FIRST) begin : g_msb
         assign word_nx = {word[WORD_W-2:0], shift_bit};
      end else begin : g_lsb
         assign word_nx = {shift_bit, word[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           word <= '0;
      else if (shift_en) word <= word_nx;
   end

   // Loaded with the last index so the first increment wraps to zero.
   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if ((state_q == ST_IDLE) && (state_d == ST_WAIT))
         cnt_q <= CNT_LAST;
      else if (state_q == ST_CLK)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_full = (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (rst)
         pad_q <= 1'b0;
      else if ((state_q == ST_WAIT) && (state_d == ST_CLK))
         pad_q <= last_i;
      else if ((state_q == ST_WAKE) && read_i)
         pad_q <= 1'b0;
   end
endmodule

// File: rtl/hs_deser.sv
module hs_deser
   import hs_deser_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter bit MSB_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              enable_i,
   input  logic              strobe_i,
   input  logic              data_i,
   input  logic              last_i,
   input  logic              read_i,
   output logic              ready_o,
   output logic              wake_o,
   output logic [WORD_W-1:0] word_o
);
   generate
      if (WORD_W < 2 || (1 << $clog2(WORD_W)) != WORD_W) begin : g_bad_width
         $error("hs_deser: WORD_W must be a power of two, at least 2");
      end
   endgenerate

   state_e            state_q;
   state_e            state_d;
   logic              cnt_full;
   logic              pad_q;
   logic [WORD_W-1:0] word;

   hs_deser_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .enable_i (enable_i),
      .strobe_i (strobe_i),
      .read_i   (read_i),
      .cnt_full (cnt_full),
      .pad      (pad_q),
      .state_q  (state_q),
      .state_d  (state_d)
   );

   hs_deser_dp #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_dp (
      .clk      (clk),
      .rst      (rst),
      .state_q  (state_q),
      .state_d  (state_d),
      .data_i   (data_i),
      .last_i   (last_i),
      .read_i   (read_i),
      .word     (word),
      .cnt_full (cnt_full),
      .pad_q    (pad_q)
   );

   assign ready_o = (state_q == ST_WAIT);
   assign wake_o  = (state_q == ST_WAKE);
   assign word_o  = (wake_o && read_i) ? word : '0;
endmodule

// File: rtl/hs_deser_chk.sv
module hs_deser_chk
   import hs_deser_pkg::*;
(
   input logic   clk,
   input logic   rst,
   input logic   enable_i,
   input logic   strobe_i,
   input logic   read_i,
   input logic   ready_o,
   input logic   wake_o,
   input logic   pad_q,
   input state_e state_q
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!ready_o && !wake_o));

   a_r2_enable_ready: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && enable_i) |=> ready_o);

   a_r3_strobe_drops_ready: assert property (@(posedge clk) disable iff (rst)
      (ready_o && strobe_i) |=> !ready_o);

   a_r3_ready_not_wake: assert property (@(posedge clk) disable iff (rst)
      !(ready_o && wake_o));

   a_r6_wake_after_hand: assert property (@(posedge clk) disable iff (rst)
      $rose(wake_o) |-> ($past(state_q) == ST_HAND));

   a_r7_wake_holds: assert property (@(posedge clk) disable iff (rst)
      (wake_o && !read_i) |=> wake_o);

   a_r9_pad_keeps_wake: assert property (@(posedge clk) disable iff (rst)
      (wake_o && read_i && pad_q) |=> (wake_o && !pad_q));

   a_r10_read_aborts: assert property (@(posedge clk) disable iff (rst)
      (ready_o && read_i) |=> (!ready_o && !wake_o));
endmodule

bind hs_deser hs_deser_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .enable_i (enable_i),
   .strobe_i (strobe_i),
   .read_i   (read_i),
   .ready_o  (ready_o),
   .wake_o   (wake_o),
   .pad_q    (pad_q),
   .state_q  (state_q)
);

// File: tb/test_hs_deser.sv
module test_hs_deser;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        enable_i = 1'b0;
   logic        strobe_i = 1'b0;
   logic        data_i = 1'b0;
   logic        last_i = 1'b0;
   logic        read_i = 1'b0;
   logic        ready_o;
   logic        wake_o;
   logic [15:0] word_o;

   int n_total = 0;
   int n_fail  = 0;

   hs_deser i_hs_deser (
      .clk(clk), .rst(rst), .enable_i(enable_i), .strobe_i(strobe_i),
      .data_i(data_i), .last_i(last_i), .read_i(read_i),
      .ready_o(ready_o), .wake_o(wake_o), .word_o(word_o)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic arm();
      enable_i = 1'b1;
      @(negedge clk);
      enable_i = 1'b0;
   endtask

   task automatic wait_ready(input string req);
      int k = 0;
      while (!ready_o && k < 60) begin
         @(negedge clk);
         k++;
      end
      if (!ready_o) chk(1'b0, req, 32'(ready_o), 32'd1);
   endtask

   // Sends bits w[15], w[14], ... for n bits; marker on the last if mark.
   task automatic send_bits(input logic [15:0] w, input int n,
                            input bit mark, input int hold);
      for (int i = 0; i < n; i++) begin
         wait_ready("R5 ready before bit");
         data_i   = w[15-i];
         last_i   = mark && (i == n - 1);
         strobe_i = 1'b1;
         @(negedge clk);
         for (int h = 0; h < hold; h++) begin
            chk(ready_o == 1'b0, "R5 ready low while strobe held",
                32'(ready_o), 32'd0);
            @(negedge clk);
         end
         strobe_i = 1'b0;
         last_i   = 1'b0;
         if (hold > 0 && i < n - 1 && !mark) begin
            @(negedge clk);
            chk(ready_o == 1'b1, "R5 ready back after strobe low",
                32'(ready_o), 32'd1);
         end
      end
   endtask

   task automatic wait_wake(input string req);
      int k = 0;
      while (!wake_o && k < 80) begin
         @(negedge clk);
         k++;
      end
      chk(wake_o == 1'b1, req, 32'(wake_o), 32'd1);
   endtask

   task automatic do_read(input logic [15:0] exp, input bit wake_after,
                          input string req);
      read_i = 1'b1;
      #1;
      chk(word_o == exp, req, 32'(word_o), 32'(exp));
      @(negedge clk);
      read_i = 1'b0;
      chk(wake_o == wake_after, req, 32'(wake_o), 32'(wake_after));
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      logic [15:0] pat;
      logic [15:0] expw;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!ready_o && !wake_o && word_o == 16'h0, "R1 during reset",
          {30'd0, ready_o, wake_o}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(!ready_o && !wake_o && word_o == 16'h0, "R1 after reset",
          {14'd0, word_o, ready_o, wake_o}, 32'd0);

      // R2: idle ignores strobe and read
      strobe_i = 1'b1; read_i = 1'b1;
      @(negedge clk);
      strobe_i = 1'b0; read_i = 1'b0;
      @(negedge clk);
      chk(!ready_o && !wake_o, "R2 idle ignores strobe/read",
          {30'd0, ready_o, wake_o}, 32'd0);
      arm();
      chk(ready_o == 1'b1, "R2 enable raises ready", 32'(ready_o), 32'd1);

      // R3: ready drops after strobe; R5: held strobe
      data_i = 1'b1; strobe_i = 1'b1;
      @(negedge clk);
      chk(ready_o == 1'b0, "R3 ready falls after strobe", 32'(ready_o), 32'd0);
      repeat (3) begin
         @(negedge clk);
         chk(ready_o == 1'b0, "R5 ready low while strobe held",
             32'(ready_o), 32'd0);
      end
      strobe_i = 1'b0;
      @(negedge clk);
      chk(ready_o == 1'b1, "R5 ready returns", 32'(ready_o), 32'd1);
      send_bits(16'h2AAA << 1, 15, 1'b0, 2);
      // first bit 1 then bits 14..0 of (0x2AAA<<1) top 15 bits
      @(negedge clk);
      chk(ready_o == 1'b0, "R6 ready low at word end", 32'(ready_o), 32'd0);
      wait_wake("R6 wake after 16 bits");
      do_read({1'b1, 15'h2AAA}, 1'b0, "R4 held-strobe word");

      // R4/R6/R7: full-word sweep
      for (int t = 0; t < 20; t++) begin
         case (t)
            16: pat = 16'h0000;
            17: pat = 16'hFFFF;
            18: pat = 16'hA5C3;
            19: pat = 16'h3C5A;
            default: pat = 16'h1 << t;
         endcase
         arm();
         send_bits(pat, 16, 1'b0, 0);
         wait_wake("R6 wake after 16 bits");
         repeat (3) @(negedge clk);
         chk(wake_o == 1'b1 && word_o == 16'h0, "R7 wake holds, bus idle",
             {15'd0, word_o, wake_o}, 32'd1);
         do_read(pat, 1'b0, "R4 word and R7 read to idle");
      end

      // R8/R9: cut-off sweep over every length
      for (int n = 1; n <= 16; n++) begin
         pat  = 16'hB6D9;
         expw = 16'((32'(pat) >> (16 - n)) << (16 - n));
         arm();
         send_bits(pat, n, 1'b1, 0);
         wait_wake("R8 wake after marker");
         do_read(expw, 1'b1, "R8 padded word, R9 wake kept");
         do_read(expw, 1'b0, "R9 second read clears");
      end

      // R10: abort while waiting for a bit
      arm();
      send_bits(16'hFFFF, 5, 1'b0, 0);
      wait_ready("R10 ready before abort");
      read_i = 1'b1;
      @(negedge clk);
      read_i = 1'b0;
      chk(!ready_o && !wake_o, "R10 abort in wait", {30'd0, ready_o, wake_o}, 32'd0);
      repeat (3) @(negedge clk);
      chk(!ready_o && !wake_o, "R10 stays idle", {30'd0, ready_o, wake_o}, 32'd0);

      // R10: abort mid-handshake
      arm();
      data_i = 1'b1; strobe_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      read_i = 1'b1;
      @(negedge clk);
      read_i = 1'b0; strobe_i = 1'b0;
      chk(!ready_o && !wake_o, "R10 abort in handshake",
          {30'd0, ready_o, wake_o}, 32'd0);
      @(negedge clk);
      chk(ready_o == 1'b0, "R10 no ready after handshake abort",
          32'(ready_o), 32'd0);
      @(negedge clk);
      chk(ready_o == 1'b0, "R10 still idle", 32'(ready_o), 32'd0);

      // R10: fresh word after abort
      arm();
      send_bits(16'h1234, 16, 1'b0, 0);
      wait_wake("R10 wake after restart");
      do_read(16'h1234, 1'b0, "R10 fresh word after abort");

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule